// File: doc/BRIEF.md
# Split-Decoded RAM/ROM Memory Bank

This block is the main-memory bank behind a CPU with a 10-bit address bus and an 8-bit data bus. It holds four RAM chip models of 128 bytes each and one ROM chip model of 512 bytes. Each chip model has two select pins. One is active high and the other is active low, and a chip works only when the high pin is 1 and the low pin is 0. Each RAM chip also has read and write strobes. A 2-to-4 decoder drives the active-high selects of the RAM chips. The top address line drives the active-low RAM selects and the active-high ROM select.

The bus is split into a read-data vector and an output-enable. The output-enable is high only while some chip drives the bus. While no chip drives, the read data is zero. RAM reads are combinational from the current address. RAM writes take effect at the rising clock edge. The ROM contents come from a constant function at elaboration. A write aimed at ROM space changes nothing and raises a one-cycle error flag.

Top module: `mem_bank`

## Requirements
- R1: With addr[9]=0, addr[8:7] selects RAM chip 0..3 and addr[6:0] selects the byte inside it, so RAM chips occupy 0x000-0x07F, 0x080-0x0FF, 0x100-0x17F and 0x180-0x1FF, and the 512 RAM bytes are all distinct. With addr[9]=1 the ROM is selected and addr[8:0] is its internal address.
- R2: wr=1 with rd=0 at a RAM address stores wdata into the addressed byte at the rising clock edge. During that cycle oe is 0.
- R3: rd=1 at a RAM address sets oe=1 and puts the stored byte on rdata in the same cycle, with no clock edge in between.
- R4: When rd=1 and wr=1 together, the access is a read. The bank returns the stored byte, and it neither stores wdata nor raises rom_wr_err.
- R5: At a RAM address with rd=0 and wr=0, oe is 0 and rdata is 0.
- R6: At any ROM address the bank drives oe=1 whatever rd and wr are. rdata equals addr[7:0] XOR 8'hA5 when addr[8]=1, and addr[7:0] XOR 8'h3C when addr[8]=0.
- R7: A cycle with wr=1, rd=0 and addr[9]=1 leaves every ROM and RAM byte unchanged. It makes rom_wr_err 1 for exactly the next clock cycle. In every other case rom_wr_err is 0 in the following cycle.
- R8: At most one chip drives at any time. oe is the OR of the chip drive enables, and rdata is 0 whenever oe is 0.
- R9: While rst_n is low, and in the first cycle after reset, rom_wr_err is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset for the error flag |
| addr | input | 10 | Bus address |
| wdata | input | 8 | Write data |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| rdata | output | 8 | Read data, zero when not driven |
| oe | output | 1 | High while some chip drives rdata |
| rom_wr_err | output | 1 | One-cycle pulse after a write to ROM space |

## Verification
On every cycle the assertions check four things. At most one chip drives the bus. A ROM address always drives and a RAM read always drives. An idle RAM access leaves the bus quiet and rdata zero. The error flag follows a write into ROM space by exactly one cycle, and only then. The data-path behaviour needs the bench's scenarios: a full write-then-read sweep of all 512 RAM bytes, a sweep of all 512 ROM words against the formula, the read-wins case with both strobes set, and readback proving that a ROM write left the contents alone.

// File: rtl/mem_bank_pkg.sv
package mem_bank_pkg;

    // Registered state of the bank
    typedef struct packed {
        logic rom_wr_err;
    } bank_state_t;

    // Constant ROM contents, evaluated at elaboration
    function automatic logic [7:0] rom_word(input logic [8:0] a);
        rom_word = a[7:0] ^ (a[8] ? 8'hA5 : 8'h3C);
    endfunction

endpackage

// File: rtl/bank_decoder.sv
module bank_decoder #(
    parameter int RAM_AW    = 7,
    parameter int RAM_CHIPS = 4,
    localparam int SEL_W    = $clog2(RAM_CHIPS),
    localparam int ADDR_W   = RAM_AW + SEL_W + 1
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [RAM_CHIPS-1:0] ram_cs_hi,
    output logic                 ram_cs_lo_n,
    output logic                 rom_cs_hi,
    output logic                 rom_cs_lo_n
);
    logic [SEL_W-1:0] chip_idx;
    assign chip_idx = addr[RAM_AW +: SEL_W];

    // 2-to-4 style decoder, one output per RAM chip
    for (genvar i = 0; i < RAM_CHIPS; i++) begin : g_dec
        assign ram_cs_hi[i] = (chip_idx == SEL_W'(i));
    end

    // Top address line: low side disables RAMs, high side enables ROM
    assign ram_cs_lo_n = addr[ADDR_W-1];
    assign rom_cs_hi   = addr[ADDR_W-1];
    assign rom_cs_lo_n = 1'b0;
endmodule

// File: rtl/bank_ram_chip.sv
module bank_ram_chip #(
    parameter int AW = 7,
    parameter int DW = 8,
    localparam int DEPTH = 2 ** AW
) (
    input  logic          clk,
    input  logic          cs_hi,
    input  logic          cs_lo_n,
    input  logic          rd,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          drive
);
    logic [DW-1:0] cells [DEPTH];
    logic          selected;
    logic          write_en;

    assign selected = cs_hi & ~cs_lo_n;
    // Read has priority over write when both strobes are high
    assign drive    = selected & rd;
    assign write_en = selected & wr & ~rd;

    always_ff @(posedge clk) begin
        if (write_en) begin
            cells[addr] <= din;
        end
    end

    assign dout = drive ? cells[addr] : '0;
endmodule

// File: rtl/bank_rom_chip.sv
module bank_rom_chip #(
    parameter int AW = 9,
    parameter int DW = 8,
    localparam int DEPTH = 2 ** AW
) (
    input  logic          cs_hi,
    input  logic          cs_lo_n,
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] dout,
    output logic          drive
);
    import mem_bank_pkg::*;

    logic [DW-1:0] cells [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_init
        assign cells[i] = DW'(rom_word(9'(i)));
    end

    // Drives as soon as it is selected, no strobe needed
    assign drive = cs_hi & ~cs_lo_n;
    assign dout  = drive ? cells[addr] : '0;
endmodule

// File: rtl/mem_bank.sv
module mem_bank #(
    parameter int RAM_AW    = 7,
    parameter int RAM_CHIPS = 4,
    parameter int DW        = 8,
    localparam int SEL_W    = $clog2(RAM_CHIPS),
    localparam int ROM_AW   = RAM_AW + SEL_W,
    localparam int ADDR_W   = ROM_AW + 1,
    localparam int N_SRC    = RAM_CHIPS + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic              rd,
    input  logic              wr,
    output logic [DW-1:0]     rdata,
    output logic              oe,
    output logic              rom_wr_err
);
    import mem_bank_pkg::*;

    logic [RAM_CHIPS-1:0] ram_cs_hi;
    logic                 ram_cs_lo_n;
    logic                 rom_cs_hi;
    logic                 rom_cs_lo_n;
    logic [DW-1:0]        src_data [N_SRC];
    logic [N_SRC-1:0]     drive_vec;
    bank_state_t          st_d, st_q;

    bank_decoder #(
        .RAM_AW    (RAM_AW),
        .RAM_CHIPS (RAM_CHIPS)
    ) dec_i (
        .addr        (addr),
        .ram_cs_hi   (ram_cs_hi),
        .ram_cs_lo_n (ram_cs_lo_n),
        .rom_cs_hi   (rom_cs_hi),
        .rom_cs_lo_n (rom_cs_lo_n)
    );

    for (genvar c = 0; c < RAM_CHIPS; c++) begin : g_ram
        bank_ram_chip #(
            .AW (RAM_AW),
            .DW (DW)
        ) ram_i (
            .clk     (clk),
            .cs_hi   (ram_cs_hi[c]),
            .cs_lo_n (ram_cs_lo_n),
            .rd      (rd),
            .wr      (wr),
            .addr    (addr[RAM_AW-1:0]),
            .din     (wdata),
            .dout    (src_data[c]),
            .drive   (drive_vec[c])
        );
    end

    bank_rom_chip #(
        .AW (ROM_AW),
        .DW (DW)
    ) rom_i (
        .cs_hi   (rom_cs_hi),
        .cs_lo_n (rom_cs_lo_n),
        .addr    (addr[ROM_AW-1:0]),
        .dout    (src_data[RAM_CHIPS]),
        .drive   (drive_vec[RAM_CHIPS])
    );

    // Bus merge: each source is zero unless it drives
    always_comb begin
        rdata = '0;
        for (int s = 0; s < N_SRC; s++) begin
            rdata = rdata | src_data[s];
        end
        oe = |drive_vec;
    end

    // Next state: flag a write that lands in ROM space
    always_comb begin
        st_d            = st_q;
        st_d.rom_wr_err = wr & ~rd & addr[ADDR_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rom_wr_err = st_q.rom_wr_err;
endmodule

// File: rtl/mem_bank_chk.sv
module mem_bank_chk #(
    parameter int ADDR_W = 10,
    parameter int DW     = 8,
    parameter int N_SRC  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              rd,
    input logic              wr,
    input logic [DW-1:0]     rdata,
    input logic              oe,
    input logic              rom_wr_err,
    input logic [N_SRC-1:0]  drive_vec
);
    logic rom_space;
    assign rom_space = addr[ADDR_W-1];

    p_one_driver_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drive_vec));

    p_quiet_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> (rdata == '0));

    p_rom_drives_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rom_space |-> oe);

    p_ram_read_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !rom_space) |-> oe);

    p_ram_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd && !rom_space) |-> !oe);

    p_rom_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !rd && rom_space) |=> rom_wr_err);

    p_no_false_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && !rd && rom_space) |=> !rom_wr_err);

    p_rom_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_space && $stable(addr)) |-> $stable(rdata));
endmodule

bind mem_bank mem_bank_chk #(
    .ADDR_W (ADDR_W),
    .DW     (DW),
    .N_SRC  (N_SRC)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .rd         (rd),
    .wr         (wr),
    .rdata      (rdata),
    .oe         (oe),
    .rom_wr_err (rom_wr_err),
    .drive_vec  (drive_vec)
);

// File: tb/mem_bank_tb_top.sv
module mem_bank_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] rdata;
    logic       oe;
    logic       rom_wr_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mem_bank dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .wdata      (wdata),
        .rd         (rd),
        .wr         (wr),
        .rdata      (rdata),
        .oe         (oe),
        .rom_wr_err (rom_wr_err)
    );

    function automatic logic [7:0] ram_pat(input int a);
        return 8'((a * 37 + 11) % 256);
    endfunction

    function automatic logic [7:0] rom_exp(input int a);
        int low;
        low = a % 256;
        return 8'((a >= 768) ? (low ^ 'hA5) : (low ^ 'h3C));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    task automatic drive(input int a, input logic [7:0] d, input logic r, input logic w);
        @(negedge clk);
        addr  = 10'(a);
        wdata = d;
        rd    = r;
        wr    = w;
        #1;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        // R9 reset state
        #1;
        check(rom_wr_err == 1'b0, "R9 flag in reset", int'(rom_wr_err), 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(rom_wr_err == 1'b0, "R9 flag after reset", int'(rom_wr_err), 0);
        check(oe == 1'b0 && rdata == 8'h00, "R5 idle at 0x000", int'({oe, rdata}), 0);

        // R2 fill all RAM bytes
        for (int a = 0; a < 512; a++) begin
            drive(a, ram_pat(a), 1'b0, 1'b1);
            check(oe == 1'b0, "R2 no drive during write", int'(oe), 0);
        end
        drive(0, 8'h00, 1'b0, 1'b0);
        check(rom_wr_err == 1'b0, "R7 no flag for RAM writes", int'(rom_wr_err), 0);

        // R1/R3 read every RAM byte back
        for (int a = 0; a < 512; a++) begin
            drive(a, 8'h00, 1'b1, 1'b0);
            check(oe == 1'b1 && rdata == ram_pat(a), "R1 R3 RAM readback",
                  int'({oe, rdata}), int'({1'b1, ram_pat(a)}));
        end

        // R5 idle RAM accesses, one per chip
        for (int c = 0; c < 4; c++) begin
            drive(c * 128 + 5, 8'hFF, 1'b0, 1'b0);
            check(oe == 1'b0 && rdata == 8'h00, "R5 idle RAM quiet", int'({oe, rdata}), 0);
        end

        // R4 both strobes: read wins, nothing stored
        drive(12'h13A, ~ram_pat('h13A), 1'b1, 1'b1);
        check(oe == 1'b1 && rdata == ram_pat('h13A), "R4 read on both strobes",
              int'({oe, rdata}), int'({1'b1, ram_pat('h13A)}));
        drive(12'h13A, 8'h00, 1'b1, 1'b0);
        check(rdata == ram_pat('h13A), "R4 nothing stored", int'(rdata), int'(ram_pat('h13A)));

        // R6 sweep ROM without strobes
        for (int a = 512; a < 1024; a++) begin
            drive(a, 8'h00, 1'b0, 1'b0);
            check(oe == 1'b1 && rdata == rom_exp(a), "R6 ROM word",
                  int'({oe, rdata}), int'({1'b1, rom_exp(a)}));
        end
        drive(12'h3C1, 8'h00, 1'b1, 1'b0);
        check(rdata == rom_exp('h3C1), "R6 ROM with rd", int'(rdata), int'(rom_exp('h3C1)));

        // R7 write into ROM space
        drive(12'h2A7, 8'h00, 1'b0, 1'b1);
        check(oe == 1'b1 && rdata == rom_exp('h2A7), "R6 ROM drives during write",
              int'({oe, rdata}), int'({1'b1, rom_exp('h2A7)}));
        drive(12'h2A7, 8'h00, 1'b0, 1'b0);
        check(rom_wr_err == 1'b1, "R7 flag after ROM write", int'(rom_wr_err), 1);
        check(rdata == rom_exp('h2A7), "R7 ROM unchanged", int'(rdata), int'(rom_exp('h2A7)));
        drive(12'h0A7, 8'h00, 1'b1, 1'b0);
        check(rom_wr_err == 1'b0, "R7 flag lasts one cycle", int'(rom_wr_err), 0);
        check(rdata == ram_pat('h0A7), "R7 RAM unchanged", int'(rdata), int'(ram_pat('h0A7)));

        // R4 both strobes in ROM space: no flag
        drive(12'h355, 8'h00, 1'b1, 1'b1);
        drive(12'h000, 8'h00, 1'b0, 1'b0);
        check(rom_wr_err == 1'b0, "R4 no flag on read-wins", int'(rom_wr_err), 0);

        // R8 quiet bus with no driver
        check(oe == 1'b0 && rdata == 8'h00, "R8 zero when undriven", int'({oe, rdata}), 0);

        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        summary();
    end
endmodule